// File: doc/BRIEF.md
# Ping-Pong Serial Line Buffer

This block stores one line of a 1-bit serial stream while it plays out the line captured before it. It has two equal banks. One bank takes bits from the write port while the other bank feeds the read port. An external toggle pulse swaps the two roles, so a line written in one period can be read in the next while a fresh line is captured.

The write and read strobes, the toggle and the control inputs come from outside the chip. They are brought onto one system clock with two-flop synchronisers, and their edges are detected there. The read length is the number of bits written before the toggle, so short lines are supported.

Each side has two controls:
- A sticky flag that blocks that side until the next toggle: buffer-full on the write side, write-request on the read side.
- Its own counter clear, for rewriting a line or replaying one.

Top module: `toggle_line_buf`

## Requirements
- R1: While `rst_ni` is low, `rd_data_o` is 0 and both `full_no` and `wreq_no` are 1. Until the first toggle, output-clock edges leave `rd_data_o` low and `wreq_no` high.
- R2: A bit is stored on a rising edge of `wr_clk_i` only while both `wr_en_ni` and `cs_ni` are 0. Stored bits take consecutive addresses starting at 0.
- R3: On each falling edge of `rd_clk_i`, while both `rd_en_ni` and `cs_ni` are 0, `rd_data_o` presents the next bit of the read bank, first-written bit first. The number of bits read equals the number written before the toggle.
- R4: A rising edge of `toggle_i` turns the bank just written into the read bank, and the former read bank into the write bank. Writes made during a read go to the other bank and do not disturb the line being read.
- R5: `full_no` goes to 0 on the write that stores bit number DEPTH. While it is 0, writes are ignored. A line shorter than DEPTH leaves `full_no` at 1.
- R6: `wreq_no` goes to 0 on the rising edge of `rd_clk_i` that follows presentation of the last bit. While it is 0, no further bits are fetched.
- R7: Once the last bit has been presented, every further enabled falling edge of `rd_clk_i` drives `rd_data_o` to the level of `idle_lvl_i`.
- R8: A rising edge of `toggle_i` returns both `full_no` and `wreq_no` to 1.
- R9: While `wr_clr_ni` is 0, the write address returns to 0 and `full_no` returns to 1, so the line is rewritten from its start. Reading is unaffected.
- R10: While `rd_clr_ni` is 0, `rd_data_o` shows the first bit of the read line at once and `wreq_no` returns to 1. The next falling edge then presents the second bit.
- R11: While `cs_ni` is 1, the clocks, the toggle and both counter clears have no effect on stored data, flags or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_clk_i | input | 1 | Write strobe; acts on its rising edge |
| wr_data_i | input | 1 | Serial write data |
| wr_en_ni | input | 1 | Write enable, active low |
| rd_clk_i | input | 1 | Read strobe; data on its falling edge, flag on its rising edge |
| rd_en_ni | input | 1 | Read enable, active low |
| toggle_i | input | 1 | Bank swap; acts on its rising edge |
| wr_clr_ni | input | 1 | Write address clear, active low |
| rd_clr_ni | input | 1 | Read address clear, active low |
| idle_lvl_i | input | 1 | Output level after the end of a line |
| rd_data_o | output | 1 | Serial read data (registered) |
| full_no | output | 1 | Buffer full, active low |
| wreq_no | output | 1 | Write request (line fully read), active low |

## Verification
The bench writes lines of different lengths and patterns and checks every bit read back against its own model of the two banks:
- A short line with an irregular pattern shows the ordering and that the length is latched at the toggle.
- A full-depth line, followed by an extra write, separates correct blocking from silent overwriting.
- Interleaving reads of one line with writes of the next shows that the banks stay independent.
- Both idle levels are shown after the last bit.
- Rewrite, replay and deselected phases each leave a pattern whose later read-out reveals whether any ignored stimulus reached the stored data.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef struct packed {
    logic wr_stb;
    logic rd_fall;
    logic rd_rise;
    logic tog;
    logic wr_clr;
    logic rd_clr;
  } tlb_evt_t;
endpackage

// File: rtl/tlb_sync.sv
`timescale 1ns/1ps
module tlb_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tlb_edge.sv
`timescale 1ns/1ps
module tlb_edge #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  tlb_sync #(.W(W), .STAGES(STAGES), .RST_VAL(RST_VAL)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(async_i),
    .sync_o (sync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= RST_VAL;
    else         prev_o <= sync_o;
  end
endmodule

// File: rtl/tlb_bank_mem.sv
`timescale 1ns/1ps
module tlb_bank_mem #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          wr_bank_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_bit_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          rd_bit_o,
  output logic          bit0_o
);
  logic [DEPTH-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DEPTH-1:0] cells_q;
    always_ff @(posedge clk_i) begin
      if (we_i && wr_bank_i == 1'(b)) cells_q[wr_idx_i] <= wr_bit_i;
    end
    assign bank_rd[b] = cells_q;
  end

  // read bank is always the one not being written
  assign rd_bit_o = bank_rd[~wr_bank_i][rd_idx_i];
  assign bit0_o   = bank_rd[~wr_bank_i][0];
endmodule

// File: rtl/tlb_wr_ctrl.sv
`timescale 1ns/1ps
module tlb_wr_ctrl #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tlb_pkg::tlb_evt_t evt_i,
  output logic          we_o,
  output logic          wr_bank_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          full_no
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign we_o = evt_i.wr_stb && full_no && !evt_i.tog && !evt_i.wr_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank_o <= 1'b0;
      wr_addr_o <= '0;
      full_no   <= 1'b1;
    end else if (evt_i.tog) begin
      wr_bank_o <= ~wr_bank_o;
      wr_addr_o <= '0;
      full_no   <= 1'b1;
    end else if (evt_i.wr_clr) begin
      wr_addr_o <= '0;
      full_no   <= 1'b1;
    end else if (we_o) begin
      wr_addr_o <= wr_addr_o + 1'b1;
      if (wr_addr_o == LAST) full_no <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_rd_ctrl.sv
`timescale 1ns/1ps
module tlb_rd_ctrl #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tlb_pkg::tlb_evt_t evt_i,
  input  logic [AW-1:0] len_i,
  input  logic          rd_bit_i,
  input  logic          bit0_i,
  input  logic          idle_lvl_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] rd_len_o,
  output logic          rd_data_o,
  output logic          wreq_no
);
  logic valid_q;
  logic at_end;

  assign at_end = (rd_addr_o == rd_len_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      rd_addr_o <= '0;
      rd_len_o  <= '0;
      rd_data_o <= 1'b0;
      wreq_no   <= 1'b1;
    end else if (evt_i.tog) begin
      valid_q   <= 1'b1;
      rd_len_o  <= len_i;
      rd_addr_o <= '0;
      wreq_no   <= 1'b1;
    end else if (valid_q) begin
      if (evt_i.rd_clr) begin
        wreq_no <= 1'b1;
        if (rd_len_o != '0) begin
          rd_data_o <= bit0_i;
          rd_addr_o <= AW'(1);
        end else begin
          rd_data_o <= idle_lvl_i;
          rd_addr_o <= '0;
        end
      end else begin
        if (evt_i.rd_fall) begin
          if (!at_end && wreq_no) begin
            rd_data_o <= rd_bit_i;
            rd_addr_o <= rd_addr_o + 1'b1;
          end else if (at_end) begin
            rd_data_o <= idle_lvl_i;
          end
        end
        if (evt_i.rd_rise && at_end) wreq_no <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/toggle_line_buf.sv
`timescale 1ns/1ps
module toggle_line_buf #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic wr_clk_i,
  input  logic wr_data_i,
  input  logic wr_en_ni,
  input  logic rd_clk_i,
  input  logic rd_en_ni,
  input  logic toggle_i,
  input  logic wr_clr_ni,
  input  logic rd_clr_ni,
  input  logic idle_lvl_i,
  output logic rd_data_o,
  output logic full_no,
  output logic wreq_no
);
  import tlb_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH + 1);
  localparam int unsigned IW = $clog2(DEPTH);

  // edge-sensed strobes: {toggle, rd_clk, wr_clk}
  logic [2:0] stb_s, stb_p;
  tlb_edge #(.W(3), .STAGES(STAGES), .RST_VAL(3'b010)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({toggle_i, rd_clk_i, wr_clk_i}),
    .sync_o (stb_s),
    .prev_o (stb_p)
  );

  // levels: {idle, rd_clr_n, wr_clr_n, rd_en_n, wr_en_n, data, cs_n}
  logic [6:0] lvl_s;
  tlb_sync #(.W(7), .STAGES(STAGES), .RST_VAL(7'b0111101)) i_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({idle_lvl_i, rd_clr_ni, wr_clr_ni, rd_en_ni, wr_en_ni, wr_data_i, cs_ni}),
    .sync_o (lvl_s)
  );

  logic cs_s, wr_d_s, wr_en_s, rd_en_s, wr_clr_s, rd_clr_s, idle_s;
  assign {idle_s, rd_clr_s, wr_clr_s, rd_en_s, wr_en_s, wr_d_s, cs_s} = lvl_s;

  tlb_evt_t evt;
  logic     act;
  assign act = !cs_s;

  always_comb begin
    evt.wr_stb  = act && stb_s[0] && !stb_p[0] && !wr_en_s;
    evt.rd_fall = act && !stb_s[1] && stb_p[1] && !rd_en_s;
    evt.rd_rise = act && stb_s[1] && !stb_p[1] && !rd_en_s;
    evt.tog     = act && stb_s[2] && !stb_p[2];
    evt.wr_clr  = act && !wr_clr_s;
    evt.rd_clr  = act && !rd_clr_s;
  end

  logic tog_evt, wr_clr_evt, rd_clr_evt;
  assign tog_evt    = evt.tog;
  assign wr_clr_evt = evt.wr_clr;
  assign rd_clr_evt = evt.rd_clr;

  logic          we, wr_bank, rd_bit, bit0;
  logic [AW-1:0] wr_addr, rd_addr, rd_len;

  tlb_wr_ctrl #(.DEPTH(DEPTH)) i_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .we_o     (we),
    .wr_bank_o(wr_bank),
    .wr_addr_o(wr_addr),
    .full_no  (full_no)
  );

  tlb_bank_mem #(.DEPTH(DEPTH)) i_mem (
    .clk_i    (clk_i),
    .we_i     (we),
    .wr_bank_i(wr_bank),
    .wr_idx_i (wr_addr[IW-1:0]),
    .wr_bit_i (wr_d_s),
    .rd_idx_i (rd_addr[IW-1:0]),
    .rd_bit_o (rd_bit),
    .bit0_o   (bit0)
  );

  tlb_rd_ctrl #(.DEPTH(DEPTH)) i_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .len_i     (wr_addr),
    .rd_bit_i  (rd_bit),
    .bit0_i    (bit0),
    .idle_lvl_i(idle_s),
    .rd_addr_o (rd_addr),
    .rd_len_o  (rd_len),
    .rd_data_o (rd_data_o),
    .wreq_no   (wreq_no)
  );
endmodule

// File: rtl/tlb_chk.sv
`timescale 1ns/1ps
module tlb_chk #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_s,
  input logic          tog_evt,
  input logic          wr_clr_evt,
  input logic          rd_clr_evt,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] rd_len,
  input logic          rd_data_o,
  input logic          full_no,
  input logic          wreq_no
);
  // R5
  full_at_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_no) |-> wr_addr == AW'(DEPTH));

  // R5
  full_blocks_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && !tog_evt && !wr_clr_evt) |=> $stable(wr_addr));

  // R6
  wreq_blocks_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wreq_no && !tog_evt && !rd_clr_evt) |=> $stable(rd_addr));

  // R8
  toggle_clears_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_evt |=> (full_no && wreq_no));

  // R3
  rd_within_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr <= rd_len);

  // R11
  deselect_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> ($stable(rd_data_o) && $stable(full_no) && $stable(wreq_no)
              && $stable(wr_addr) && $stable(rd_addr)));
endmodule

bind toggle_line_buf tlb_chk #(.DEPTH(DEPTH), .AW(AW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s      (cs_s),
  .tog_evt   (tog_evt),
  .wr_clr_evt(wr_clr_evt),
  .rd_clr_evt(rd_clr_evt),
  .wr_addr   (wr_addr),
  .rd_addr   (rd_addr),
  .rd_len    (rd_len),
  .rd_data_o (rd_data_o),
  .full_no   (full_no),
  .wreq_no   (wreq_no)
);

// File: tb/test_toggle_line_buf.sv
`timescale 1ns/1ps
module test_toggle_line_buf;
  localparam int unsigned DEPTH  = 8;
  localparam int          SETTLE = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic wr_clk = 1'b0, wr_d = 1'b0, wr_en_n = 1'b1;
  logic rd_clk = 1'b1, rd_en_n = 1'b1, tog = 1'b0;
  logic wr_clr_n = 1'b1, rd_clr_n = 1'b1, idle = 1'b0;
  logic rd_data, full_n, wreq_n;

  always #2 clk = ~clk;

  toggle_line_buf #(.DEPTH(DEPTH)) i_toggle_line_buf (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n),
    .wr_clk_i(wr_clk), .wr_data_i(wr_d), .wr_en_ni(wr_en_n),
    .rd_clk_i(rd_clk), .rd_en_ni(rd_en_n), .toggle_i(tog),
    .wr_clr_ni(wr_clr_n), .rd_clr_ni(rd_clr_n), .idle_lvl_i(idle),
    .rd_data_o(rd_data), .full_no(full_n), .wreq_no(wreq_n)
  );

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  bit   wline[$];
  bit   rline[$];
  bit   exp_q[$];
  bit   have_rd = 1'b0;
  logic last_out = 1'b0;
  logic exp_wreq = 1'b1;

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_flags(string req);
    chk(req, "full_no", full_n, logic'(wline.size() < DEPTH));
    chk(req, "wreq_no", wreq_n, exp_wreq);
  endtask

  // driver: write one bit, model the bank being filled
  task automatic wr_bit(bit b);
    wr_d = b;
    idle_cyc(2);
    wr_clk = 1'b1;
    idle_cyc(SETTLE);
    wr_clk = 1'b0;
    idle_cyc(SETTLE);
    if (!cs_n && !wr_en_n && wline.size() < DEPTH) wline.push_back(b);
  endtask

  // driver: toggle pushes the captured line into the scoreboard queue
  task automatic do_toggle();
    tog = 1'b1;
    idle_cyc(SETTLE);
    tog = 1'b0;
    idle_cyc(SETTLE);
    if (!cs_n) begin
      rline = wline;
      wline = {};
      exp_q = rline;
      have_rd = 1'b1;
      exp_wreq = 1'b1;
    end
  endtask

  // monitor: one output clock, pop and compare
  task automatic rd_step(string req);
    rd_clk = 1'b0;
    idle_cyc(SETTLE);
    if (!cs_n && !rd_en_n && have_rd)
      last_out = (exp_q.size() > 0) ? logic'(exp_q.pop_front()) : idle;
    chk(req, "rd_data_o", rd_data, last_out);
    rd_clk = 1'b1;
    idle_cyc(SETTLE);
    if (!cs_n && !rd_en_n && have_rd && exp_q.size() == 0) exp_wreq = 1'b0;
  endtask

  task automatic wr_clear();
    wr_clr_n = 1'b0;
    idle_cyc(SETTLE);
    wr_clr_n = 1'b1;
    idle_cyc(SETTLE);
    if (!cs_n) wline = {};
  endtask

  task automatic rd_clear();
    rd_clr_n = 1'b0;
    idle_cyc(SETTLE);
    rd_clr_n = 1'b1;
    idle_cyc(SETTLE);
    if (!cs_n && have_rd) begin
      exp_q = rline;
      exp_wreq = 1'b1;
      last_out = (exp_q.size() > 0) ? logic'(exp_q.pop_front()) : idle;
    end
  endtask

  initial begin
    idle_cyc(3);
    chk("R1", "rd_data_o in reset", rd_data, 1'b0);
    chk_flags("R1");
    rst_n = 1'b1;
    idle_cyc(3);
    cs_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b0;
    idle_cyc(4);
    rd_step("R1");
    rd_step("R1");
    chk_flags("R1");

    // R2: short line 1,0,1,1,0; a disabled write must not land
    wr_bit(1); wr_bit(0); wr_bit(1); wr_bit(1); wr_bit(0);
    wr_en_n = 1'b1; wr_bit(1); wr_en_n = 1'b0;
    chk_flags("R5");
    do_toggle();
    chk_flags("R8");
    for (int i = 0; i < 5; i++) rd_step("R2");
    chk_flags("R6");
    idle = 1'b1; rd_step("R7");
    idle = 1'b0; rd_step("R7");
    chk_flags("R6");

    // full line, then one blocked write
    for (int i = 0; i < DEPTH; i++) wr_bit(bit'(i % 3 == 0));
    chk_flags("R5");
    wr_bit(1);
    chk_flags("R5");
    do_toggle();
    chk_flags("R8");

    // R4: read the full line while writing 1,0,1 into the other bank
    for (int i = 0; i < DEPTH; i++) begin
      rd_step("R4");
      if (i < 3) wr_bit(bit'(i != 1));
    end
    rd_step("R5");
    do_toggle();
    rd_step("R4");

    // R9: rewrite during a read
    for (int i = 0; i < DEPTH; i++) wr_bit(1);
    chk_flags("R9");
    wr_clear();
    chk_flags("R9");
    wr_bit(1); wr_bit(0); wr_bit(0);
    rd_step("R9"); rd_step("R9"); rd_step("R9");
    chk_flags("R6");

    // R10: replay
    do_toggle();
    rd_step("R3"); rd_step("R3"); rd_step("R3"); rd_step("R3");
    chk_flags("R6");
    rd_clear();
    chk("R10", "rd_data_o after clear", rd_data, last_out);
    chk_flags("R10");
    rd_step("R10"); rd_step("R10");
    idle = 1'b1; rd_step("R7");
    chk_flags("R6");

    // R11: deselected activity is ignored
    wr_bit(0); wr_bit(1);
    cs_n = 1'b1;
    wr_bit(1); wr_bit(1);
    do_toggle();
    rd_clear();
    rd_step("R11");
    wr_clear();
    chk_flags("R11");
    cs_n = 1'b0;
    idle_cyc(4);
    do_toggle();
    rd_step("R11"); rd_step("R11"); rd_step("R11");
    chk_flags("R11");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule